// File: doc/BRIEF.md
# Paced Frame Packet Generator

This block is a traffic source. It spreads a programmed volume of data evenly across a repeating time window. When each window opens it takes a snapshot of its settings: the byte budget for the window, the nominal packet size, the window length in clock cycles and the destination identifier. From these it works out how many packets the window needs. It then releases those packets one at a time, with a fixed spacing between packet starts. The final packet of a window carries only the bytes that are left, so it may be shorter than the others.

Every packet leaves on a ready/valid word stream. The first word is a header. The header is followed by payload words that hold a counting pattern, so a downstream checker can confirm that nothing was dropped or reordered. Downstream stalls delay packets but are never made up later. If a window closes with packets still waiting to start, those packets are dropped and a sticky flag records the loss.

Top module: `paced_pkt_gen`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `overrun` are all low.
- R2: Each window sends ceil(total_bytes / pkt_bytes) packets. Their header sequence numbers run 0, 1, 2, ... and restart at 0 in the next window.
- R3: The header word carries the destination ID in bits [31:24], the packet byte length in bits [23:12] and the sequence number in bits [11:0]. `out_last` is low on the header.
- R4: Every packet of a window has a length of pkt_bytes, except the last one. The last packet carries total_bytes minus the bytes already sent.
- R5: A header is followed by ceil(length / 4) payload words. The payload words count up from 0, starting with the first packet of each window. `out_last` is high on the final payload word only.
- R6: When nothing stalls, consecutive packet starts within a window are floor(interval_cycles / count) cycles apart. The first packets of back-to-back windows are interval_cycles apart.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady. A packet whose slot has already passed starts two cycles after the previous packet's last word is accepted. Later spacing is measured from that actual start.
- R8: When a window opens while packets of the previous window have not yet started, those packets are dropped and the new window begins at sequence 0. `overrun` then goes high and stays high until reset.
- R9: When total_bytes or pkt_bytes is zero, the window sends no packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the window timer; when low, no new window opens |
| total_bytes | input | TOT_W | Byte budget per window |
| pkt_bytes | input | LEN_W | Nominal packet size in bytes |
| interval_cycles | input | CYC_W | Window length in cycles |
| dest_id | input | ID_W | Destination identifier placed in headers |
| out_ready | input | 1 | Downstream can accept a word |
| out_valid | output | 1 | A word is offered |
| out_data | output | ID_W+LEN_W+SEQ_W | Header or payload word |
| out_last | output | 1 | Final word of a packet |
| overrun | output | 1 | Sticky flag: unstarted packets were dropped |

## Verification
The bench builds the block with its default parameters:
- 16-bit byte budget and window counters.
- An 8/12/12 header split, which gives 32-bit words of four bytes.

With these values it can run windows of a few hundred cycles with packets from one byte up to 200 bytes. That covers several cases:
- A remainder of a single byte.
- A single packet per window.
- Spacing that is tighter than the packet length, which forces an overrun.
- A long stall that pushes a packet past its slot.

// File: rtl/paced_pkt_gen.sv
module paced_pkt_gen #(
  parameter int TOT_W = 16,
  parameter int CYC_W = 16,
  parameter int ID_W  = 8,
  parameter int LEN_W = 12,
  parameter int SEQ_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic [TOT_W-1:0]            total_bytes,
  input  logic [LEN_W-1:0]            pkt_bytes,
  input  logic [CYC_W-1:0]            interval_cycles,
  input  logic [ID_W-1:0]             dest_id,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [ID_W+LEN_W+SEQ_W-1:0] out_data,
  output logic                        out_last,
  output logic                        overrun
);

  localparam int DW  = ID_W + LEN_W + SEQ_W;
  localparam int BPW = DW / 8;
  localparam int BSH = $clog2(BPW);
  localparam int MW  = (TOT_W > CYC_W) ? TOT_W : CYC_W;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} st_t;

  st_t              st_q;
  logic [CYC_W-1:0] icnt_q, ivl_q, gap_q, gcnt_q;
  logic [TOT_W-1:0] cnt_q, left_q, rem_q;
  logic [LEN_W-1:0] pkt_q, wleft_q, plen, nwords;
  logic [ID_W-1:0]  dest_q;
  logic [SEQ_W-1:0] seq_q;
  logic [DW-1:0]    hdr_q, pay_q;
  logic             calc_q, ovr_q;
  logic [TOT_W:0]   tsum;
  logic [TOT_W-1:0] cnt_calc;
  logic [CYC_W-1:0] gap_calc;
  logic             istart, go, xfer;

  assign istart   = enable && (icnt_q == '0);
  assign tsum     = (TOT_W+1)'(total_bytes) + (TOT_W+1)'(pkt_bytes) - (TOT_W+1)'(1);
  assign cnt_calc = (pkt_bytes == '0) ? '0 : TOT_W'(tsum / (TOT_W+1)'(pkt_bytes));
  assign gap_calc = (cnt_q == '0) ? '0 : CYC_W'(MW'(ivl_q) / MW'(cnt_q));
  assign plen     = (rem_q < TOT_W'(pkt_q)) ? LEN_W'(rem_q) : pkt_q;
  assign nwords   = LEN_W'(((LEN_W+1)'(plen) + (LEN_W+1)'(BPW - 1)) >> BSH);
  assign go       = (st_q == S_IDLE) && !istart && !calc_q && (left_q != '0) && (gcnt_q == '0);
  assign xfer     = out_valid && out_ready;

  assign out_valid = (st_q != S_IDLE);
  assign out_data  = (st_q == S_HDR) ? hdr_q : pay_q;
  assign out_last  = (st_q == S_PAY) && (wleft_q == LEN_W'(1));
  assign overrun   = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt_q <= '0;
    end else if (!enable) begin
      icnt_q <= '0;
    end else if ((CYC_W+1)'(icnt_q) + (CYC_W+1)'(1) >= (CYC_W+1)'(interval_cycles)) begin
      icnt_q <= '0;
    end else begin
      icnt_q <= icnt_q + CYC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      left_q <= '0;
      rem_q  <= '0;
      pkt_q  <= '0;
      dest_q <= '0;
      ivl_q  <= '0;
      gap_q  <= '0;
      gcnt_q <= '0;
      seq_q  <= '0;
      hdr_q  <= '0;
      calc_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (istart) begin
      if (left_q != '0) ovr_q <= 1'b1;
      cnt_q  <= cnt_calc;
      left_q <= cnt_calc;
      rem_q  <= total_bytes;
      pkt_q  <= pkt_bytes;
      dest_q <= dest_id;
      ivl_q  <= interval_cycles;
      seq_q  <= '0;
      gcnt_q <= '0;
      calc_q <= 1'b1;
    end else begin
      calc_q <= 1'b0;
      if (calc_q) gap_q <= gap_calc;
      if (go) begin
        left_q <= left_q - TOT_W'(1);
        rem_q  <= rem_q - TOT_W'(plen);
        seq_q  <= seq_q + SEQ_W'(1);
        hdr_q  <= {dest_q, plen, seq_q};
        gcnt_q <= (gap_q == '0) ? '0 : gap_q - CYC_W'(1);
      end else if (gcnt_q != '0) begin
        gcnt_q <= gcnt_q - CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      wleft_q <= '0;
      pay_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (go) begin
          st_q    <= S_HDR;
          wleft_q <= nwords;
          if (seq_q == '0) pay_q <= '0;
        end
        S_HDR: if (out_ready) st_q <= (wleft_q == '0) ? S_IDLE : S_PAY;
        S_PAY: if (out_ready) begin
          pay_q   <= pay_q + DW'(1);
          wleft_q <= wleft_q - LEN_W'(1);
          if (wleft_q == LEN_W'(1)) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8

  AST_HDR_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (st_q == S_HDR) |-> (out_data[DW-ID_W-1:SEQ_W] != '0) && !out_last); // R4

  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && out_last |=> !out_valid); // R5

endmodule

// File: tb/paced_pkt_gen_test.sv
module paced_pkt_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // total, pkt, interval, expected count, expected spacing, expected last length
  localparam int VEC [0:NV-1][0:5] = '{
    '{100,  32, 200, 4,  50,   4},
    '{64,   64, 120, 1, 120,  64},
    '{50,    7, 300, 8,  37,   1},
    '{1000, 200, 400, 5,  80, 200},
    '{30,    0, 150, 0,   0,   0},
    '{0,    16, 150, 0,   0,   0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, out_ready = 1'b1;
  logic [15:0] total_bytes = '0, interval_cycles = '0;
  logic [11:0] pkt_bytes = '0;
  logic [7:0]  dest_id = '0;
  logic        out_valid, out_last, overrun;
  logic [31:0] out_data;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;
  int nh, in_pkt, exp_w, wcnt, pexp, bad_pay, bad_last;
  int h_t [0:63];
  int h_end [0:63];
  int h_w [0:63];
  logic [31:0] h_d [0:63];

  paced_pkt_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .total_bytes(total_bytes),
    .pkt_bytes(pkt_bytes), .interval_cycles(interval_cycles), .dest_id(dest_id),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (in_pkt == 0) begin
        if (nh < 64) begin h_t[nh] = cyc; h_d[nh] = out_data; end
        nh++;
        if (out_last) bad_last++;
        exp_w = (int'(out_data[23:12]) + 3) / 4;
        if (out_data[11:0] == 12'd0) pexp = 0;
        wcnt = 0;
        in_pkt = 1;
      end else begin
        if (out_data != 32'(pexp)) bad_pay++;
        pexp++;
        wcnt++;
        if (out_last != (wcnt == exp_w)) bad_last++;
        if (wcnt == exp_w) begin
          in_pkt = 0;
          if (nh - 1 < 64) begin h_w[nh-1] = wcnt; h_end[nh-1] = cyc; end
        end
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nh = 0; in_pkt = 0; exp_w = 0; wcnt = 0; pexp = 0; bad_pay = 0; bad_last = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid after reset", out_valid == 1'b0, out_valid, 0);
    chk("R1 last after reset", out_last == 1'b0, out_last, 0);
    chk("R1 overrun after reset", overrun == 1'b0, overrun, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      int cnt, ivl, bad_d, bad_s, bad_l, bad_w, bad_g;
      cnt = VEC[v][3]; ivl = VEC[v][2];
      #1;
      clear_mon();
      total_bytes = 16'(VEC[v][0]); pkt_bytes = 12'(VEC[v][1]);
      interval_cycles = 16'(ivl); dest_id = 8'(8'h30 + v);
      out_ready = 1'b1;
      @(posedge clk); #1 enable = 1'b1;
      repeat (2*ivl - 5) @(posedge clk);
      #1 enable = 1'b0;
      repeat (ivl + 60) @(posedge clk);
      @(negedge clk);
      if (cnt == 0) begin
        chk("R9 no packets for zero setting", nh == 0, nh, 0);
      end else begin
        chk("R2 packet count over two windows", nh == 2*cnt, nh, 2*cnt);
        bad_d = 0; bad_s = 0; bad_l = 0; bad_w = 0; bad_g = 0;
        for (int k = 0; k < nh && k < 64; k++) begin
          int el;
          el = (k % cnt == cnt - 1) ? VEC[v][5] : VEC[v][1];
          if (h_d[k][31:24] != 8'(8'h30 + v)) bad_d++;
          if (int'(h_d[k][11:0]) != k % cnt) bad_s++;
          if (int'(h_d[k][23:12]) != el) bad_l++;
          if (h_w[k] != (el + 3) / 4) bad_w++;
          if (k % cnt != 0 && h_t[k] - h_t[k-1] != VEC[v][4]) bad_g++;
        end
        chk("R3 destination field", bad_d == 0, bad_d, 0);
        chk("R2 sequence numbers", bad_s == 0, bad_s, 0);
        chk("R4 packet lengths", bad_l == 0, bad_l, 0);
        chk("R5 payload word counts", bad_w == 0, bad_w, 0);
        chk("R5 payload pattern", bad_pay == 0, bad_pay, 0);
        chk("R5 last flag", bad_last == 0, bad_last, 0);
        chk("R6 packet spacing", bad_g == 0, bad_g, 0);
        chk("R6 window period", h_t[cnt] - h_t[0] == ivl, h_t[cnt] - h_t[0], ivl);
      end
      chk("R8 no overrun when paced", overrun == 1'b0, overrun, 0);
    end

    // R7: stall the first packet past its slot
    @(posedge clk); #1;
    clear_mon();
    total_bytes = 16'd40; pkt_bytes = 12'd16; interval_cycles = 16'd300; dest_id = 8'h77;
    out_ready = 1'b0;
    @(posedge clk); #1 enable = 1'b1;
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk("R7 header held while stalled", out_valid && out_data == 32'h7701_0000,
        out_data, 32'h7701_0000);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (135) @(posedge clk);
    #1 enable = 1'b0;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R7 packets after stall", nh == 3, nh, 3);
    chk("R7 late start after previous last", h_t[1] - h_end[0] == 2, h_t[1] - h_end[0], 2);
    chk("R7 spacing from actual start", h_t[2] - h_t[1] == 100, h_t[2] - h_t[1], 100);
    chk("R4 short final packet", h_d[2][23:12] == 12'd8, h_d[2][23:12], 8);
    chk("R5 payload after stall", bad_pay == 0 && bad_last == 0, bad_pay + bad_last, 0);

    // R8: spacing tighter than packets forces drops
    @(posedge clk); #1;
    clear_mon();
    total_bytes = 16'd400; pkt_bytes = 12'd16; interval_cycles = 16'd100; dest_id = 8'h5A;
    @(posedge clk); #1 enable = 1'b1;
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk("R8 overrun raised", overrun == 1'b1, overrun, 1);
    begin
      int restart, prev;
      restart = 0; prev = 0;
      for (int k = 1; k < nh && k < 64; k++)
        if (restart == 0 && h_d[k][11:0] == 12'd0) begin restart = k; prev = int'(h_d[k-1][11:0]); end
      chk("R8 new window restarts at sequence 0", restart > 0, restart, 1);
      chk("R8 tail of old window dropped", prev < 24, prev, 23);
    end
    @(posedge clk); #1 enable = 1'b0;
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk("R8 overrun stays set", overrun == 1'b1, overrun, 1);
    chk("R5 payload across overrun", bad_pay == 0 && bad_last == 0, bad_pay + bad_last, 0);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 overrun cleared by reset", overrun == 1'b0 && out_valid == 1'b0, overrun, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule